// File: doc/BRIEF.md
# Dual-Loop PLL Powerdown Controller

This block sequences powerdown for the two loops of a dual PLL synthesizer. Each loop has its own load strobe. On that strobe the block captures two control bits for the loop: a charge-pump float bit and a powerdown bit. Together they choose one of four settings: fully active, active with a floating charge pump, powerdown deferred until the charge pump is floating, or immediate powerdown.

A per-loop flag from the analog side reports that the charge pump output is currently floating. This flag is asynchronous to the control clock, so it passes through a two-flop synchronizer before it can complete a deferred powerdown. For each loop, the block drives a powerdown state, a command that holds the R and N dividers in their load state, and a command that debiases the RF input. One shared output turns the reference oscillator off, but only while both loops are powered down. The strobes keep working in every powerdown state, so a loop can always be reprogrammed or woken.

Top module: `pll_pwrdn_ctrl`

## Requirements
- R1: While reset is asserted and right after it, every bit of pd_o, hold_o and debias_o is 0 and osc_off_o is 0.
- R2: A strobe on loop i with float bit 1 and powerdown bit 1 sets pd_o[i] to 1 on the same clock edge that samples the strobe.
- R3: A strobe on loop i with float bit 0 and powerdown bit 1 leaves the loop up and marks a deferred powerdown. pd_o[i] rises on the third rising edge after cp_tri_i[i] goes high and stays high.
- R4: A strobe on loop i with powerdown bit 0 clears pd_o[i] on the sampling edge. This holds for either float bit value and for either mode in which the loop went down. Without a strobe, a powered-down loop stays down.
- R5: A strobe with powerdown bit 0 that arrives before a deferred powerdown completes cancels it. A later high cp_tri_i[i] then leaves the loop up.
- R6: hold_o[i] and debias_o[i] are both 1 exactly while loop i is powered down.
- R7: osc_off_o is 1 only while both loops are powered down.
- R8: Strobes are accepted while a loop is powered down, in either mode.
- R9: A strobe or a cp_tri_i change on one loop never changes the other loop's outputs.
- R10: A deferred-powerdown strobe on a loop that is already down keeps it down.
- R11: cp_tri_i[i] has no effect while loop i has no deferred powerdown marked.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| latch_i | input | LOOPS | Per-loop load strobe, one cycle wide |
| tri_bit_i | input | LOOPS | Charge-pump float bit, captured on the strobe |
| pd_bit_i | input | LOOPS | Powerdown bit, captured on the strobe |
| cp_tri_i | input | LOOPS | Asynchronous flag: charge pump is floating |
| pd_o | output | LOOPS | Per-loop powerdown state |
| hold_o | output | LOOPS | Hold R and N dividers in load state |
| debias_o | output | LOOPS | Debias RF input to high impedance |
| osc_off_o | output | 1 | Disable the shared reference oscillator |

## Verification
Results arrive at three different latencies. Strobe-driven results (immediate entry, wake-up, cancel) appear right after the edge that samples the strobe, so they are checked at the next falling edge. A deferred entry completes on the third rising edge after the charge-pump flag rises. The bench checks that the loop is still up after the first and second edges and down after the third. The table-driven part waits four edges after every stimulus before it compares, so each steady state has settled before it is checked.

// File: rtl/pll_pwrdn_ctrl.sv
module pll_pwrdn_ctrl #(
  parameter int LOOPS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LOOPS-1:0] latch_i,
  input  logic [LOOPS-1:0] tri_bit_i,
  input  logic [LOOPS-1:0] pd_bit_i,
  input  logic [LOOPS-1:0] cp_tri_i,
  output logic [LOOPS-1:0] pd_o,
  output logic [LOOPS-1:0] hold_o,
  output logic [LOOPS-1:0] debias_o,
  output logic             osc_off_o
);

  logic [LOOPS-1:0] down;

  for (genvar g = 0; g < LOOPS; g++) begin : g_loop
    logic s1, s2, pend;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1      <= 1'b0;
        s2      <= 1'b0;
        pend    <= 1'b0;
        down[g] <= 1'b0;
      end else begin
        s1 <= cp_tri_i[g];
        s2 <= s1;
        if (latch_i[g]) begin
          if (!pd_bit_i[g]) begin
            down[g] <= 1'b0;
            pend    <= 1'b0;
          end else if (tri_bit_i[g]) begin
            down[g] <= 1'b1;
            pend    <= 1'b0;
          end else if (!down[g]) begin
            pend    <= 1'b1;
          end
        end else if (pend && s2) begin
          down[g] <= 1'b1;
          pend    <= 1'b0;
        end
      end
    end
  end

  assign pd_o      = down;
  assign hold_o    = down;
  assign debias_o  = down;
  assign osc_off_o = &down;

endmodule

module pll_pwrdn_ctrl_chk #(
  parameter int LOOPS = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [LOOPS-1:0] latch_i,
  input logic [LOOPS-1:0] tri_bit_i,
  input logic [LOOPS-1:0] pd_bit_i,
  input logic [LOOPS-1:0] cp_tri_i,
  input logic [LOOPS-1:0] pd_o,
  input logic [LOOPS-1:0] hold_o,
  input logic [LOOPS-1:0] debias_o,
  input logic             osc_off_o
);

  for (genvar g = 0; g < LOOPS; g++) begin : g_chk
    a_r2_async_entry: assert property (@(posedge clk) disable iff (!rst_n)
      latch_i[g] && pd_bit_i[g] && tri_bit_i[g] |=> pd_o[g]);

    a_r4_power_up: assert property (@(posedge clk) disable iff (!rst_n)
      latch_i[g] && !pd_bit_i[g] |=> !pd_o[g]);

    a_r4_stay_down: assert property (@(posedge clk) disable iff (!rst_n)
      pd_o[g] && !latch_i[g] |=> pd_o[g]);

    a_r3_sync_needs_cp: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pd_o[g]) && !$past(latch_i[g]) |-> $past(cp_tri_i[g], 3));

    a_r6_hold_debias: assert property (@(posedge clk) disable iff (!rst_n)
      hold_o[g] == debias_o[g]);
  end

  a_r7_osc_needs_all: assert property (@(posedge clk) disable iff (!rst_n)
    !(&pd_o) |-> !osc_off_o);

  a_r7_osc_when_all: assert property (@(posedge clk) disable iff (!rst_n)
    (&hold_o) |-> osc_off_o);

endmodule

bind pll_pwrdn_ctrl pll_pwrdn_ctrl_chk #(.LOOPS(LOOPS)) u_chk (
  .clk(clk), .rst_n(rst_n), .latch_i(latch_i), .tri_bit_i(tri_bit_i),
  .pd_bit_i(pd_bit_i), .cp_tri_i(cp_tri_i), .pd_o(pd_o), .hold_o(hold_o),
  .debias_o(debias_o), .osc_off_o(osc_off_o)
);

// File: tb/sim_pll_pwrdn_ctrl.sv
module sim_pll_pwrdn_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] latch_i = '0, tri_bit_i = '0, pd_bit_i = '0, cp_tri_i = '0;
  logic [1:0] pd_o, hold_o, debias_o;
  logic osc_off_o;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pll_pwrdn_ctrl #(.LOOPS(2)) u0 (
    .clk(clk), .rst_n(rst_n), .latch_i(latch_i), .tri_bit_i(tri_bit_i),
    .pd_bit_i(pd_bit_i), .cp_tri_i(cp_tri_i), .pd_o(pd_o), .hold_o(hold_o),
    .debias_o(debias_o), .osc_off_o(osc_off_o)
  );

  // fields: latch[10:9] tri[8:7] pd[6:5] cp[4:3] exp_pd[2:1] exp_osc[0]
  localparam logic [10:0] VEC [10] = '{
    {2'b11, 2'b11, 2'b00, 2'b00, 2'b00, 1'b0},  // R4 float only, loops up
    {2'b01, 2'b01, 2'b01, 2'b00, 2'b01, 1'b0},  // R2 immediate loop0, R9
    {2'b10, 2'b00, 2'b10, 2'b00, 2'b01, 1'b0},  // R3 deferred loop1 waits
    {2'b00, 2'b00, 2'b00, 2'b10, 2'b11, 1'b1},  // R3 completes, R7
    {2'b01, 2'b00, 2'b00, 2'b10, 2'b10, 1'b0},  // R4 wake loop0, R8
    {2'b01, 2'b00, 2'b01, 2'b00, 2'b10, 1'b0},  // R3 deferred loop0
    {2'b01, 2'b00, 2'b00, 2'b00, 2'b10, 1'b0},  // R5 cancel
    {2'b00, 2'b00, 2'b00, 2'b01, 2'b10, 1'b0},  // R5 R11 cp ignored
    {2'b10, 2'b00, 2'b10, 2'b00, 2'b10, 1'b0},  // R10 stays down
    {2'b11, 2'b11, 2'b00, 2'b00, 2'b00, 1'b0}   // R4 R8 wake both
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_all(input string req, input logic [1:0] epd, input logic eosc);
    chk(pd_o == epd, req, pd_o, epd);
    chk(hold_o == epd && debias_o == epd, {req, " R6"}, {hold_o, debias_o}, {epd, epd});
    chk(osc_off_o == eosc, {req, " R7"}, osc_off_o, eosc);
  endtask

  initial begin
    #1;
    chk_all("R1 in reset", 2'b00, 1'b0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_all("R1 after reset", 2'b00, 1'b0);

    for (int i = 0; i < 10; i++) begin
      latch_i = VEC[i][10:9]; tri_bit_i = VEC[i][8:7];
      pd_bit_i = VEC[i][6:5]; cp_tri_i = VEC[i][4:3];
      @(negedge clk);
      latch_i = '0;
      repeat (3) @(negedge clk);
      chk_all($sformatf("vector %0d", i), VEC[i][2:1], VEC[i][0]);
    end

    // R3 exact latency of deferred entry
    latch_i = 2'b01; tri_bit_i = 2'b00; pd_bit_i = 2'b01; cp_tri_i = 2'b00;
    @(negedge clk);
    latch_i = '0;
    cp_tri_i = 2'b01;
    @(negedge clk);
    chk(pd_o == 2'b00, "R3 edge1", pd_o, 0);
    @(negedge clk);
    chk(pd_o == 2'b00, "R3 edge2", pd_o, 0);
    @(negedge clk);
    chk(pd_o == 2'b01, "R3 edge3", pd_o, 1);

    // R2 exact latency of immediate entry, R7 both down
    latch_i = 2'b10; tri_bit_i = 2'b10; pd_bit_i = 2'b10;
    @(negedge clk);
    latch_i = '0;
    chk_all("R2 one edge", 2'b11, 1'b1);

    // R4 wake loop1 one edge later, R9 loop0 untouched
    latch_i = 2'b10; pd_bit_i = 2'b00; tri_bit_i = 2'b00;
    @(negedge clk);
    latch_i = '0;
    chk_all("R4 R9 wake", 2'b01, 1'b0);

    // R1 reset mid-run
    rst_n = 1'b0;
    #1;
    chk_all("R1 reset mid-run", 2'b00, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule